// File: doc/BRIEF.md
# Pulse Tone Channel with Direct Level Mode

This block generates a square-wave tone from a programmable 12-bit period and a 3-bit duty setting. A 4-bit level appears on its sample output. A down-counter runs on every clock, which is the CPU clock. Each time the counter passes zero, a 16-step duty sequencer moves one step. The sample equals the programmed volume for part of the sixteen steps and zero for the rest.

Software programs the channel through a small write port: a 2-bit register index, 8 bits of data and a write strobe. A mode bit bypasses the waveform. In that mode the volume field becomes a raw 4-bit level that software streams to the output. Clearing the enable bit silences the channel and returns its phase to the starting point.

Top module: `pulse_tone_chan`

## Requirements
- R1: A write with `wr_en` high takes effect at that clock edge, and the decoded fields show on `sample` at once. Index 0 holds the control fields: bit 7 is the direct-level mode, bits 6:4 are the duty D and bits 3:0 are the volume V. Index 1 holds period bits 7:0. Index 2 holds period bits 11:8 in its bits 3:0 and the channel enable in its bit 7.
- R2: A write to index 3, or any input cycle with `wr_en` low, changes no register and leaves `sample` on its expected course.
- R3: While the enable bit is clear, `sample` is 0.
- R4: While the channel is enabled and the mode bit is set, `sample` equals V. A new V written in this mode appears at the edge of the write.
- R5: In tone mode the sequencer step counts down from 15 and wraps to 15 after 0. `sample` is V while the step is at or below D and 0 otherwise, so V shows for D+1 of every 16 steps.
- R6: Each step lasts F+1 clocks, which gives a waveform period of (F+1)×16 clocks. F here is the period held in the registers before the enabling write. The first step change comes F+1 clocks after the enabling edge.
- R7: Clearing the enable bit returns the step to 15 and keeps the divider loaded with F. A later re-enable restarts the waveform from its starting phase.
- R8: After reset, all registers are zero, the step is 15 and `sample` is 0. Reset during a running tone silences it at once.
- R9: With F = 0 the step moves on every clock.
- R10: D = 7 gives V for 8 of 16 steps. D = 0 gives V for exactly one step in 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock (CPU clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index (0 control, 1 period low, 2 period high and enable, 3 unused) |
| wr_data | input | 8 | Register write data |
| sample | output | 4 | Channel output level |

## Verification
The bound checker watches, on every cycle:
- that a disabled channel stays silent;
- that the output equals the volume in direct-level mode;
- that the output only ever takes the values 0 or V;
- that the sequencer holds between divider wraps and drops by exactly one on each wrap;
- that the divider counts down, reloads from the period on wrap and while disabled, and returns the step to 15 while disabled.

Only the bench scenarios can show the end-to-end timing of the waveform. These cover:
- the duty fraction over whole periods for small, zero and multi-byte periods;
- the phase restart after re-enable;
- the ignored index 3 and idle write cycles;
- a reset taken while a tone is running.

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;

   // Width of the register index on the write port
   localparam int IDX_W = 2;

   // Register indices; the period-high slot also carries the enable bit
   typedef enum logic [IDX_W-1:0] {
      RIDX_CTRL  = 2'd0,
      RIDX_PLOW  = 2'd1,
      RIDX_PHIGH = 2'd2,
      RIDX_SPARE = 2'd3
   } reg_idx_e;

endpackage

// File: rtl/pulse_tone_regs.sv
module pulse_tone_regs
   import pulse_tone_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DUTY_W = 3,
   parameter int VOL_W  = 4,
   parameter int PER_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mode,
   output logic [DUTY_W-1:0] duty,
   output logic [VOL_W-1:0]  vol,
   output logic [PER_W-1:0]  period,
   output logic              chan_en
);
   localparam int HI_W = PER_W - DATA_W;

   logic [DATA_W-1:0] per_lo_q;
   logic [HI_W-1:0]   per_hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= 1'b0;
         duty     <= '0;
         vol      <= '0;
         per_lo_q <= '0;
         per_hi_q <= '0;
         chan_en  <= 1'b0;
      end else if (wr_en) begin
         unique case (reg_idx_e'(wr_idx))
            RIDX_CTRL:  {mode, duty, vol} <= wr_data;
            RIDX_PLOW:  per_lo_q <= wr_data;
            RIDX_PHIGH: begin
               per_hi_q <= wr_data[HI_W-1:0];
               chan_en  <= wr_data[DATA_W-1];
            end
            default: ;
         endcase
      end
   end

   assign period = {per_hi_q, per_lo_q};

endmodule

// File: rtl/pulse_tone_div.sv
module pulse_tone_div #(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   output logic             tick,
   output logic [PER_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!run || count == '0) begin
         count <= period;
      end else begin
         count <= count - 1'b1;
      end
   end

   assign tick = run && (count == '0);

endmodule

// File: rtl/pulse_tone_seq.sv
module pulse_tone_seq #(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   output logic [STEP_W-1:0] step
);
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         step <= '1;
      end else if (tick) begin
         step <= step - 1'b1;
      end
   end

endmodule

// File: rtl/pulse_tone_mix.sv
module pulse_tone_mix #(
   parameter int STEP_W = 4,
   parameter int DUTY_W = 3,
   parameter int VOL_W  = 4
) (
   input  logic              run,
   input  logic              mode,
   input  logic [DUTY_W-1:0] duty,
   input  logic [VOL_W-1:0]  vol,
   input  logic [STEP_W-1:0] step,
   output logic [VOL_W-1:0]  sample
);
   logic in_high;

   always_comb begin
      in_high = mode || (step <= STEP_W'(duty));
      sample  = (run && in_high) ? vol : '0;
   end

endmodule

// File: rtl/pulse_tone_chan.sv
module pulse_tone_chan
   import pulse_tone_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PER_W  = 12,
   parameter int STEP_W = 4,
   parameter int DUTY_W = 3,
   parameter int VOL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [VOL_W-1:0]  sample
);
   localparam int HI_W = PER_W - DATA_W;

   // Elaboration-time parameter checks
   if (DATA_W != 1 + DUTY_W + VOL_W) begin : g_bad_ctrl
      $error("control fields must fill the data word exactly");
   end
   if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_period
      $error("period high part must fit below the enable bit");
   end
   if (DUTY_W >= STEP_W) begin : g_bad_duty
      $error("duty field must be narrower than the step index");
   end

   logic              mode_w;
   logic [DUTY_W-1:0] duty_w;
   logic [VOL_W-1:0]  vol_w;
   logic [PER_W-1:0]  period_w;
   logic              en_w;
   logic              tick_w;
   logic [PER_W-1:0]  count_w;
   logic [STEP_W-1:0] step_w;

   pulse_tone_regs #(
      .DATA_W(DATA_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W), .PER_W(PER_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .mode(mode_w), .duty(duty_w), .vol(vol_w),
      .period(period_w), .chan_en(en_w)
   );

   pulse_tone_div #(.PER_W(PER_W)) i_div (
      .clk(clk), .rst_n(rst_n), .run(en_w), .period(period_w),
      .tick(tick_w), .count(count_w)
   );

   pulse_tone_seq #(.STEP_W(STEP_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .run(en_w), .tick(tick_w), .step(step_w)
   );

   pulse_tone_mix #(
      .STEP_W(STEP_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W)
   ) i_mix (
      .run(en_w), .mode(mode_w), .duty(duty_w), .vol(vol_w),
      .step(step_w), .sample(sample)
   );

endmodule

// File: rtl/pulse_tone_chk.sv
module pulse_tone_chk #(
   parameter int PER_W  = 12,
   parameter int STEP_W = 4,
   parameter int VOL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              mode,
   input logic [VOL_W-1:0]  vol,
   input logic [PER_W-1:0]  period,
   input logic              tick,
   input logic [PER_W-1:0]  count,
   input logic [STEP_W-1:0] step,
   input logic [VOL_W-1:0]  sample
);
   // R3
   silent_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> sample == '0);

   // R4
   pcm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && mode) |-> sample == vol);

   // R5
   two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample == '0 || sample == vol);

   // R6
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !tick) |=> $stable(step));

   // R5
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && tick) |=> step == STEP_W'($past(step) - 1'b1));

   // R7
   idle_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (step == '1 && count == $past(period)));

   // R6
   cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && count != '0) |=> count == PER_W'($past(count) - 1'b1));

   // R6
   cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && count == '0) |=> count == $past(period));

endmodule

bind pulse_tone_chan pulse_tone_chk #(
   .PER_W(PER_W), .STEP_W(STEP_W), .VOL_W(VOL_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(en_w), .mode(mode_w), .vol(vol_w),
   .period(period_w), .tick(tick_w), .count(count_w), .step(step_w),
   .sample(sample)
);

// File: tb/test_pulse_tone_chan.sv
module test_pulse_tone_chan;

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_idx = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [3:0] sample;

   exp_item_t exp_q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Reference state, kept from the requirements
   logic        m_mode, m_en;
   logic [2:0]  m_duty;
   logic [3:0]  m_vol, m_hi;
   logic [7:0]  m_lo;
   int          m_f, m_n;

   always #10 clk = ~clk;

   pulse_tone_chan i_pulse_tone_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .sample(sample)
   );

   function automatic logic [3:0] ref_sample();
      int stp;
      if (!m_en) return 4'd0;
      if (m_mode) return m_vol;
      stp = 15 - ((m_n / (m_f + 1)) % 16);
      return (stp <= int'(m_duty)) ? m_vol : 4'd0;
   endfunction

   function automatic void model_clear();
      m_mode = 0; m_en = 0; m_duty = 0; m_vol = 0;
      m_hi = 0; m_lo = 0; m_f = 0; m_n = 0;
   endfunction

   // Driver: one clock with given inputs, then push the expected sample
   task automatic cyc(input logic we, input logic [1:0] idx,
                      input logic [7:0] d, input string tag);
      int  f_before;
      bit  en_before;
      exp_item_t it;
      @(negedge clk);
      wr_en = we; wr_idx = idx; wr_data = d;
      @(posedge clk);
      f_before  = int'({m_hi, m_lo});
      en_before = m_en;
      if (we) begin
         case (idx)
            2'd0: {m_mode, m_duty, m_vol} = d;
            2'd1: m_lo = d;
            2'd2: begin m_hi = d[3:0]; m_en = d[7]; end
            default: ;
         endcase
      end
      if (m_en && en_before) m_n++;
      else begin
         m_n = 0;
         if (m_en) m_f = f_before;
      end
      it.exp = ref_sample();
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, tag);
   endtask

   task automatic do_reset(input string tag);
      exp_item_t it;
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      @(posedge clk);
      model_clear();
      it.exp = 4'd0; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_item_t it;
         it = exp_q.pop_front();
         n_tests++;
         if (sample !== it.exp) begin
            n_fail++;
            $display("FAIL %s: sample=%0d expected %0d at %0t",
                     it.tag, sample, it.exp, $time);
         end
      end
   end

   initial begin
      model_clear();
      repeat (2) @(posedge clk);
      do_reset("R8 reset");
      idle(3, "R8 idle after reset");

      // Tone with F=2, D=3, V=9
      cyc(1, 2'd0, 8'h39, "R1 ctrl");
      cyc(1, 2'd1, 8'h02, "R1 period low");
      cyc(1, 2'd2, 8'h00, "R3 period high, disabled");
      idle(4, "R3 silent before enable");
      cyc(1, 2'd2, 8'h80, "R1 enable");
      idle(3 * 16 * 2, "R5 duty 3 waveform");

      // Ignored index and strobe-low cycles
      cyc(1, 2'd3, 8'hFF, "R2 spare index");
      cyc(0, 2'd0, 8'hFF, "R2 strobe low ctrl");
      cyc(0, 2'd2, 8'h00, "R2 strobe low disable");
      idle(20, "R2 course unchanged");

      // Direct-level mode
      cyc(1, 2'd0, 8'h85, "R4 level 5");
      idle(8, "R4 hold 5");
      cyc(1, 2'd0, 8'h8C, "R4 level 12");
      cyc(1, 2'd0, 8'hF3, "R4 level 3 duty ignored");
      idle(6, "R4 hold 3");
      cyc(1, 2'd0, 8'h39, "R5 back to tone");
      idle(20, "R5 tone resumes");

      // Disable silences
      cyc(1, 2'd2, 8'h00, "R3 disable");
      cyc(1, 2'd0, 8'h8F, "R3 write while off");
      idle(10, "R3 silent");

      // Multi-byte period F=261, D=0, V=15
      cyc(1, 2'd0, 8'h0F, "R1 ctrl duty 0");
      cyc(1, 2'd1, 8'h05, "R1 period low");
      cyc(1, 2'd2, 8'h01, "R1 period high off");
      cyc(1, 2'd2, 8'h81, "R6 enable long period");
      idle(262 * 16 + 300, "R6 long period");
      cyc(1, 2'd2, 8'h01, "R7 disable mid-step");
      idle(5, "R7 off");
      cyc(1, 2'd2, 8'h81, "R7 re-enable");
      idle(262 * 16 + 20, "R7 phase restart");

      // F = 0, D = 7
      cyc(1, 2'd2, 8'h00, "R3 off");
      cyc(1, 2'd1, 8'h00, "R9 period zero");
      cyc(1, 2'd0, 8'h7A, "R10 duty 7");
      cyc(1, 2'd2, 8'h80, "R9 enable");
      idle(48, "R9 step every clock, R10 half duty");

      // D = 0, F = 1
      cyc(1, 2'd2, 8'h00, "R3 off");
      cyc(1, 2'd1, 8'h01, "R6 period one");
      cyc(1, 2'd0, 8'h03, "R10 duty 0");
      cyc(1, 2'd2, 8'h80, "R10 enable");
      idle(2 * 16 * 2, "R10 one step in sixteen");

      // Reset while running
      cyc(1, 2'd0, 8'h8E, "R4 level 14");
      do_reset("R8 reset while running");
      idle(4, "R8 silent after reset");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule